// File: doc/BRIEF.md
# Receive Byte Buffer with Dual-Mode Host Access

This block stores bytes from a serial-bus receiver, each with a small per-byte status code, in an eight-entry first-in first-out buffer. A host reaches the buffer in one of two access styles. In the parallel style, reading the data removes the head byte. In the paired (SPI-style) style, reading the data leaves the byte in place, and only a flush command removes it. The flush may be given in the same transfer as the read.

The block drives one level-sensitive interrupt request. By default it is raised when an incoming byte is lost because the buffer is full. When the interrupt-mode input is high, it is also raised when a byte lands in an empty buffer. Later arrivals do not raise it again until the buffer has been drained to empty. A status read clears the request.

The status byte and the head data are formed only from registered state. During a transfer they therefore show the state from before that transfer, and any removal or flag change appears one cycle later.

Top module: `rxHostFifo`

## Requirements
- R1: After reset the buffer is empty, `irqReq` is 0, and `hostStatus` reads 0x01.
- R2: Bytes leave in the order they arrived. `hostData` shows the head byte. `hostStatus[7:4]` shows the status code of the head entry, or 0 when the buffer is empty.
- R3: A push into a buffer that already holds 8 bytes is dropped, whether or not a pop happens in the same cycle. The drop sets the overflow flag (`hostStatus[2]`) and raises `irqReq` whatever the interrupt mode is. `hostStatus[1]` is the full flag.
- R4: With `spiMode`=0, `rdData` removes the head byte at the clock edge, and `flush` has no effect.
- R5: With `spiMode`=1, `rdData` alone removes nothing. `flush` removes the head byte. `flush` together with `rdData` returns the head byte and removes it.
- R6: A removal request on an empty buffer changes nothing. `hostStatus[0]` is the empty flag.
- R7: With `intMode`=1, a byte accepted into an empty buffer raises `irqReq` on the next cycle. Bytes accepted into a non-empty buffer do not raise it. Once the buffer has been drained, the next arrival raises it again.
- R8: With `intMode`=0, an accepted byte does not raise `irqReq`.
- R9: `irqReq` stays high until a cycle with `rdStatus`. That cycle clears `irqReq` and the overflow flag. If a new interrupt event occurs in that same cycle, the event wins.
- R10: In a cycle where `rdStatus`, `rdData` or `flush` is high, `hostStatus`, `hostData` and `irqReq` still show the state from before that transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxPush | input | 1 | Receiver offers a byte this cycle |
| rxData | input | DATA_W | Received byte |
| rxStat | input | STAT_W | Status code of the received byte |
| spiMode | input | 1 | 1 = paired access with explicit flush, 0 = parallel access |
| intMode | input | 1 | 1 = also interrupt on arrival into an empty buffer |
| rdStatus | input | 1 | Host reads the status byte |
| rdData | input | 1 | Host reads the head data byte |
| flush | input | 1 | Host flush command (acts only in paired access) |
| hostData | output | DATA_W | Head data byte, 0 when empty |
| hostStatus | output | STAT_W+4 | {head status code, 0, overflow, full, empty} |
| irqReq | output | 1 | Interrupt request level |

## Verification
All outputs are driven from registers, so a push, removal, flag change or interrupt becomes visible exactly one clock edge after the cycle that requests it. No output changes within the request cycle itself. The bench applies each stimulus just after a falling edge. It checks the result after the next falling edge, which leaves exactly one rising edge in between. For R10, the bench also samples in the middle of the request cycle, before the edge, to confirm that nothing has moved early.

// File: rtl/rxHostPkg.sv
package rxHostPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;  // store incoming byte
    logic rdEn;  // remove head byte
  } fifoStrb_t;
endpackage

// File: rtl/rxHostDatapath.sv
module rxHostDatapath
  import rxHostPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrb_t         strb,
  input  logic [DATA_W-1:0] inData,
  input  logic [STAT_W-1:0] inStat,
  output logic [DATA_W-1:0] headData,
  output logic [STAT_W-1:0] headStat,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [STAT_W-1:0] statMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign headData = empty ? '0 : dataMem[rdPtr];
  assign headStat = empty ? '0 : statMem[rdPtr];

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      dataMem[wrPtr] <= inData;
      statMem[wrPtr] <= inStat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.wrEn) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strb.rdEn) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({strb.wrEn, strb.rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_wr_not_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> !full);
  p_rd_not_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |-> !empty);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  p_pop_shrinks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !strb.wrEn) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/rxHostControl.sv
module rxHostControl
  import rxHostPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxPush,
  input  logic      spiMode,
  input  logic      intMode,
  input  logic      rdStatus,
  input  logic      rdData,
  input  logic      flush,
  input  logic      empty,
  input  logic      full,
  output fifoStrb_t strb,
  output logic      ovfFlag,
  output logic      irqReq
);
  logic dropEvt, arriveEvt, popReq;

  assign popReq    = spiMode ? flush : rdData;
  assign dropEvt   = rxPush && full;
  assign arriveEvt = intMode && rxPush && empty;

  always_comb begin
    strb      = '0;
    strb.wrEn = rxPush && !full;
    strb.rdEn = popReq && !empty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      irqReq  <= 1'b0;
    end else begin
      if (dropEvt)       ovfFlag <= 1'b1;
      else if (rdStatus) ovfFlag <= 1'b0;
      if (dropEvt || arriveEvt) irqReq <= 1'b1;
      else if (rdStatus)        irqReq <= 1'b0;
    end
  end

  p_arrive_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && empty && intMode) |=> irqReq);
  p_spi_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (spiMode && !flush) |-> !strb.rdEn);
  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(rxPush && full));
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !rdStatus) |=> irqReq);
endmodule

// File: rtl/rxHostFifo.sv
module rxHostFifo
  import rxHostPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxData,
  input  logic [STAT_W-1:0] rxStat,
  input  logic              spiMode,
  input  logic              intMode,
  input  logic              rdStatus,
  input  logic              rdData,
  input  logic              flush,
  output logic [DATA_W-1:0] hostData,
  output logic [STAT_W+3:0] hostStatus,
  output logic              irqReq
);
  fifoStrb_t         strb;
  logic              empty, full, ovfFlag;
  logic [STAT_W-1:0] headStat;

  rxHostControl uCtrl (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .spiMode(spiMode),
    .intMode(intMode), .rdStatus(rdStatus), .rdData(rdData), .flush(flush),
    .empty(empty), .full(full), .strb(strb), .ovfFlag(ovfFlag), .irqReq(irqReq)
  );

  rxHostDatapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .STAT_W(STAT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(rxData), .inStat(rxStat),
    .headData(hostData), .headStat(headStat), .empty(empty), .full(full)
  );

  assign hostStatus = {headStat, 1'b0, ovfFlag, full, empty};

  p_reset_empty_r1: assert property (@(posedge clk)
    !rstN |=> (hostStatus[0] && !irqReq));
endmodule

// File: tb/tb_rxHostFifo.sv
`timescale 1ns/1ps
module tb_rxHostFifo;
  logic clk = 1'b0, rstN = 1'b0;
  logic rxPush = 0, spiMode = 0, intMode = 0, rdStatus = 0, rdData = 0, flush = 0;
  logic [7:0] rxData = '0;
  logic [3:0] rxStat = '0;
  logic [7:0] hostData, hostStatus;
  logic irqReq;
  int checks = 0, fails = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  rxHostFifo dut (.clk(clk), .rstN(rstN), .rxPush(rxPush), .rxData(rxData),
    .rxStat(rxStat), .spiMode(spiMode), .intMode(intMode), .rdStatus(rdStatus),
    .rdData(rdData), .flush(flush), .hostData(hostData),
    .hostStatus(hostStatus), .irqReq(irqReq));

  typedef struct packed {
    logic push; logic [7:0] d; logic [3:0] s;
    logic spi; logic imod; logic rdS; logic rdD; logic fl;
    logic [7:0] eD; logic [7:0] eS; logic eI;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1,8'hA1,4'h3,1'b0,1'b0,1'b0,1'b0,1'b0,8'hA1,8'h30,1'b0},
    '{1'b1,8'hB2,4'h5,1'b0,1'b0,1'b0,1'b0,1'b0,8'hA1,8'h30,1'b0},
    '{1'b0,8'h00,4'h0,1'b0,1'b0,1'b0,1'b1,1'b0,8'hB2,8'h50,1'b0},
    '{1'b0,8'h00,4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,8'hB2,8'h50,1'b0},
    '{1'b0,8'h00,4'h0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,8'h01,1'b0},
    '{1'b0,8'h00,4'h0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,8'h01,1'b0},
    '{1'b1,8'hC3,4'h1,1'b1,1'b0,1'b0,1'b0,1'b0,8'hC3,8'h10,1'b0},
    '{1'b0,8'h00,4'h0,1'b1,1'b0,1'b0,1'b1,1'b0,8'hC3,8'h10,1'b0},
    '{1'b1,8'hD4,4'h2,1'b1,1'b0,1'b0,1'b1,1'b1,8'hD4,8'h20,1'b0},
    '{1'b0,8'h00,4'h0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,8'h01,1'b0},
    '{1'b0,8'h00,4'h0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,8'h01,1'b0},
    '{1'b1,8'hE5,4'h6,1'b0,1'b1,1'b0,1'b0,1'b0,8'hE5,8'h60,1'b1},
    '{1'b0,8'h00,4'h0,1'b0,1'b1,1'b1,1'b0,1'b0,8'hE5,8'h60,1'b0},
    '{1'b1,8'hF6,4'h7,1'b0,1'b1,1'b0,1'b0,1'b0,8'hE5,8'h60,1'b0},
    '{1'b0,8'h00,4'h0,1'b0,1'b1,1'b0,1'b1,1'b0,8'hF6,8'h70,1'b0},
    '{1'b0,8'h00,4'h0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,8'h01,1'b0},
    '{1'b1,8'h17,4'h8,1'b0,1'b1,1'b0,1'b0,1'b0,8'h17,8'h80,1'b1},
    '{1'b0,8'h00,4'h0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,8'h01,1'b0}
  };
  localparam string TAGS [NV] = '{"R8","R2","R4","R4","R4","R6","R5","R5","R5",
    "R5","R6","R7","R9","R7","R2","R6","R7","R9"};

  task automatic check(string req, logic [7:0] eD, logic [7:0] eS, logic eI);
    checks++;
    if (hostData !== eD || hostStatus !== eS || irqReq !== eI) begin
      fails++;
      $display("FAIL %s: data=%h status=%h irq=%b expected data=%h status=%h irq=%b",
               req, hostData, hostStatus, irqReq, eD, eS, eI);
    end
  endtask

  task automatic idle();
    rxPush = 0; rdStatus = 0; rdData = 0; flush = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 8'h01, 1'b0);
    rstN = 1;
    @(negedge clk);
    // Table walk: apply at negedge, one rising edge, check at next negedge
    for (int i = 0; i < NV; i++) begin
      rxPush = VECS[i].push; rxData = VECS[i].d; rxStat = VECS[i].s;
      spiMode = VECS[i].spi; intMode = VECS[i].imod;
      rdStatus = VECS[i].rdS; rdData = VECS[i].rdD; flush = VECS[i].fl;
      @(negedge clk);
      check(TAGS[i], VECS[i].eD, VECS[i].eS, VECS[i].eI);
    end
    idle(); spiMode = 0; intMode = 0;
    // R3: fill to full, then overflow
    for (int k = 0; k < 8; k++) begin
      rxPush = 1; rxData = 8'h10 + 8'(k); rxStat = 4'(k);
      @(negedge clk);
    end
    idle();
    check("R3", 8'h10, 8'h02, 1'b0);
    rxPush = 1; rxData = 8'h99; rxStat = 4'hF;
    @(negedge clk);
    idle();
    check("R3", 8'h10, 8'h06, 1'b1);
    // R10: mid-cycle sample while status read is asserted
    rdStatus = 1;
    #5;
    check("R10", 8'h10, 8'h06, 1'b1);
    @(negedge clk);
    idle();
    check("R9", 8'h10, 8'h02, 1'b0);
    // R9: drop event wins over status-read clear in the same cycle
    rxPush = 1; rxData = 8'h98; rdStatus = 1;
    @(negedge clk);
    idle();
    check("R9", 8'h10, 8'h06, 1'b1);
    // R3: drop still happens when a pop shares the cycle
    rxPush = 1; rxData = 8'h97; rxStat = 4'hE; rdData = 1;
    #5;
    check("R10", 8'h10, 8'h06, 1'b1);
    @(negedge clk);
    idle();
    check("R3", 8'h11, {4'h1, 4'h4}, 1'b1);
    // R2: drain rest in order; overflow stays until status read
    for (int k = 1; k < 8; k++) begin
      rdData = 1;
      @(negedge clk);
      idle();
      if (k < 7) check("R2", 8'h10 + 8'(k + 1), {4'(k + 1), 4'h4}, 1'b1);
      else       check("R2", 8'h00, 8'h05, 1'b1);
    end
    rdStatus = 1;
    @(negedge clk);
    idle();
    check("R9", 8'h00, 8'h01, 1'b0);
    // R1: reset during activity
    rxPush = 1; rxData = 8'h55; rxStat = 4'h2; intMode = 1;
    @(negedge clk);
    idle();
    check("R7", 8'h55, 8'h20, 1'b1);
    rstN = 0;
    @(negedge clk);
    check("R1", 8'h00, 8'h01, 1'b0);
    rstN = 1;
    @(negedge clk);
    finishRun();
  end
endmodule